// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is an up-counter with a programmable wrap point, intended for use as a core-local tick source or a free-running cycle counter. Software loads a start value and a limit value through a small register write port. While the run bit is set, the counter advances by one on every clock. On the cycle after it has reached the limit, it returns to zero. Live state is read back through a combinational read port.

Each wrap is a "limit hit". When interrupts are enabled, a limit hit latches a pending flag that drives the interrupt output. The flag stays set through later hits until software writes the control register again. A write that keeps interrupt-enable set acknowledges the interrupt and re-arms it, so periodic operation is obtained by re-arming after every event and one-shot operation by not re-arming. The same hardware serves both modes.

Two state machines carry the control state. The run machine has the states RUN_IDLE and RUN_ACTIVE and changes state only on a control write, following the run bit (start: RUN_IDLE→RUN_ACTIVE; stop: RUN_ACTIVE→RUN_IDLE). The interrupt machine has the states IRQ_OFF, IRQ_ARMED and IRQ_PEND, with these transitions:
- arm: IRQ_OFF→IRQ_ARMED, on a control write with enable set.
- fire: IRQ_ARMED→IRQ_PEND, on a limit hit with no control write in the same cycle.
- acknowledge: IRQ_PEND→IRQ_ARMED, on a control write with enable set.
- disable: any state→IRQ_OFF, on a control write with enable clear.

Top module: `ivl_timer`

## Requirements
- R1: After reset the count reads 0, the limit reads all ones, the control register reads 0, the status reads 0 and `irq` is low.
- R2: In RUN_ACTIVE the count rises by exactly one per clock cycle. In RUN_IDLE it holds its value. A control write takes effect from the following cycle, so the edge that performs the write still uses the old run state.
- R3: When the count equals the limit while running, the next count is 0 and that cycle is a limit hit.
- R4: Counting past the all-ones value wraps to zero. With the limit at all ones this gives a free-running counter. With a limit below the current count, the counter runs up to all ones, wraps to zero and only then can match the limit.
- R5: A limit hit in IRQ_ARMED, without a control write in the same cycle, sets the pending flag from the next cycle. `irq` always equals the pending flag.
- R6: Once pending, the flag stays set through any number of further limit hits until a control write.
- R7: Any control write clears the pending flag from the next cycle, and this takes precedence over a limit hit in the same cycle. With enable set the write re-arms the interrupt; with enable clear it disables it, and no later hit raises `irq`.
- R8: A count write loads the written value in that cycle in place of the increment, and the old value does not produce a limit hit.
- R9: A limit write leaves the count untouched; the count keeps incrementing in that cycle.
- R10: Register select code 0 is the count, 1 the limit, 2 control and 3 status. In control, bit 0 is run and bit 1 is interrupt-enable. In status, bit 0 is pending. All other bits read 0.
- R11: Instances share no state; activity on one never changes another's count or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_sel | input | 2 | Register selected for writing (R10 codes) |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register selected for reading (R10 codes) |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Interrupt output, equal to the pending flag |

## Verification
The bench builds one instance with the default width of 32 and a second with `CNT_W` = 8. The 32-bit instance covers the limit compare, one-shot and periodic operation, and acknowledge precedence. It reaches all-ones wraps by loading counts just below the top. The 8-bit instance makes a natural overflow wrap reachable in a handful of cycles. It also serves as an idle neighbour for showing that the two instances are independent.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } ivl_sel_e;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_st_e;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_PEND  = 2'd2
    } irq_st_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int STAT_PEND_BIT = 0;

endpackage

// File: rtl/ivl_count.sv
module ivl_count
    import ivl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             run_req,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_din,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    run_st_e          run_st, run_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             at_lim;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_st <= RUN_IDLE;
        else        run_st <= run_nx;
    end

    // next-state: start / stop on control writes only
    always_comb begin
        run_nx = run_st;
        unique case (run_st)
            RUN_IDLE:   if (ctrl_wr && run_req)  run_nx = RUN_ACTIVE;
            RUN_ACTIVE: if (ctrl_wr && !run_req) run_nx = RUN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = (run_st == RUN_ACTIVE);
        at_lim  = (cnt_q == lim);
        hit     = running && !cnt_wr && at_lim;
    end

    // counter datapath: load > wrap > increment > hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= cnt_din;
        else if (running) cnt_q <= at_lim ? '0 : cnt_q + ONE;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ivl_irq.sv
module ivl_irq
    import ivl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ie_req,
    input  logic hit,
    output logic irq,
    output logic ie
);

    irq_st_e st, nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IRQ_OFF;
        else        st <= nx;
    end

    // transitions: arm, fire, acknowledge, disable
    always_comb begin
        nx = st;
        unique case (st)
            IRQ_OFF: begin
                if (ctrl_wr && ie_req) nx = IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (ctrl_wr)  nx = ie_req ? IRQ_ARMED : IRQ_OFF;
                else if (hit) nx = IRQ_PEND;
            end
            IRQ_PEND: begin
                if (ctrl_wr)  nx = ie_req ? IRQ_ARMED : IRQ_OFF;
            end
            default:          nx = IRQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        irq = (st == IRQ_PEND);
        ie  = (st == IRQ_ARMED) || (st == IRQ_PEND);
    end

endmodule

// File: rtl/ivl_regs.sv
module ivl_regs
    import ivl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] din,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic             running,
    input  logic             ie,
    input  logic             pend,
    output logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] rd_data
);

    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lim_q <= '1;
        else if (lim_wr) lim_q <= din;
    end

    assign lim = lim_q;

    always_comb begin
        rd_data = '0;
        unique case (ivl_sel_e'(rd_sel))
            SEL_COUNT: rd_data = cnt;
            SEL_LIMIT: rd_data = lim_q;
            SEL_CTRL: begin
                rd_data[CTRL_RUN_BIT] = running;
                rd_data[CTRL_IE_BIT]  = ie;
            end
            SEL_STAT:  rd_data[STAT_PEND_BIT] = pend;
        endcase
    end

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    logic             cnt_wr, lim_wr, ctrl_wr;
    logic [CNT_W-1:0] cnt_w, lim_w;
    logic             run_w, hit_w, ie_w;

    always_comb begin
        cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
        lim_wr  = wr_en && (wr_sel == SEL_LIMIT);
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    end

    ivl_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .run_req (wr_data[CTRL_RUN_BIT]),
        .cnt_wr  (cnt_wr),
        .cnt_din (wr_data),
        .lim     (lim_w),
        .cnt     (cnt_w),
        .running (run_w),
        .hit     (hit_w)
    );

    ivl_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .ie_req  (wr_data[CTRL_IE_BIT]),
        .hit     (hit_w),
        .irq     (irq),
        .ie      (ie_w)
    );

    ivl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lim_wr  (lim_wr),
        .din     (wr_data),
        .rd_sel  (rd_sel),
        .cnt     (cnt_w),
        .running (run_w),
        .ie      (ie_w),
        .pend    (irq),
        .lim     (lim_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic             running,
    input logic             hit,
    input logic             ie,
    input logic             irq
);

    logic cwr, kwr;
    assign cwr = wr_en && (wr_sel == 2'd2);
    assign kwr = wr_en && (wr_sel == 2'd0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !kwr && cnt != lim) |=> (cnt == $past(cnt) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !kwr) |=> $stable(cnt));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !kwr && cnt == lim) |=> (cnt == '0));

    a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ie && !cwr) |=> irq);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cwr) |=> irq);

    a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> !irq);

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        kwr |=> (cnt == $past(wr_data)));

    a_r5_no_ie: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !irq) |=> !irq);

endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cnt     (cnt_w),
    .lim     (lim_w),
    .running (run_w),
    .hit     (hit_w),
    .ie      (ie_w),
    .irq     (irq)
);

// File: tb/ivl_timer_test.sv
module ivl_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 29;
    localparam int VW = 77;

    // {we, wsel[2], wdata[32], wait[8], rsel[2], exp[32]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 2'd2, 32'd0,          8'd0,  2'd2, 32'd0},
        {1'b1, 2'd1, 32'd10,         8'd0,  2'd1, 32'd10},
        {1'b1, 2'd0, 32'd5,          8'd3,  2'd0, 32'd5},
        {1'b1, 2'd2, 32'd1,          8'd4,  2'd0, 32'd9},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd0, 32'd10},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd0, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd0,  2'd3, 32'd0},
        {1'b1, 2'd2, 32'd3,          8'd8,  2'd0, 32'd9},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd3, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd3, 32'd1},
        {1'b0, 2'd0, 32'd0,          8'd11, 2'd3, 32'd1},
        {1'b1, 2'd2, 32'd3,          8'd0,  2'd3, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd9,  2'd3, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd3, 32'd1},
        {1'b1, 2'd2, 32'd1,          8'd0,  2'd3, 32'd0},
        {1'b1, 2'd0, 32'd20,         8'd0,  2'd0, 32'd20},
        {1'b1, 2'd1, 32'd3,          8'd0,  2'd0, 32'd21},
        {1'b1, 2'd0, 32'hFFFFFFFE,   8'd2,  2'd0, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd3,  2'd0, 32'd3},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd0, 32'd0},
        {1'b1, 2'd1, 32'hFFFFFFFF,   8'd0,  2'd1, 32'hFFFFFFFF},
        {1'b1, 2'd0, 32'hFFFFFFFD,   8'd2,  2'd0, 32'hFFFFFFFF},
        {1'b0, 2'd0, 32'd0,          8'd1,  2'd0, 32'd0},
        {1'b1, 2'd2, 32'd3,          8'd0,  2'd2, 32'd3},
        {1'b1, 2'd1, 32'd5,          8'd3,  2'd0, 32'd5},
        {1'b1, 2'd2, 32'd3,          8'd0,  2'd3, 32'd0},
        {1'b0, 2'd0, 32'd0,          8'd6,  2'd3, 32'd1},
        {1'b1, 2'd2, 32'd0,          8'd5,  2'd0, 32'd1},
        {1'b0, 2'd0, 32'd0,          8'd0,  2'd3, 32'd0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 20, 23:           return "R10";
            2, 3, 4, 7, 27:         return "R2";
            5, 19, 24:              return "R3";
            6, 8, 9, 26:            return "R5";
            10, 13:                 return "R6";
            11, 12, 14, 25, 28:     return "R7";
            15:                     return "R8";
            16:                     return "R9";
            default:                return "R4";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq;

    logic        b_wr_en = 1'b0;
    logic [1:0]  b_wr_sel = '0;
    logic [7:0]  b_wr_data = '0;
    logic [1:0]  b_rd_sel = '0;
    logic [7:0]  b_rd_data;
    logic        b_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivl_timer #(.CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    ivl_timer #(.CNT_W(8)) uut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_sel(b_wr_sel),
        .wr_data(b_wr_data), .rd_sel(b_rd_sel), .rd_data(b_rd_data), .irq(b_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_a(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr_b(input logic [1:0] sel, input logic [7:0] d);
        b_wr_en = 1'b1; b_wr_sel = sel; b_wr_data = d;
        @(negedge clk);
        b_wr_en = 1'b0;
    endtask

    task automatic rd_b(input logic [1:0] sel, output logic [31:0] v);
        b_rd_sel = sel;
        #1;
        v = {24'd0, b_rd_data};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_a(2'd0, v); chk("R1 count", v, 32'd0);
        rd_a(2'd1, v); chk("R1 limit", v, 32'hFFFFFFFF);
        rd_a(2'd2, v); chk("R1 control", v, 32'd0);
        rd_a(2'd3, v); chk("R1 status", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] e;
            e = VEC[i];
            if (e[76]) begin
                wr_en = 1'b1; wr_sel = e[75:74]; wr_data = e[73:42];
                @(negedge clk);
                wr_en = 1'b0;
            end
            repeat (int'(e[41:34])) @(negedge clk);
            rd_a(e[33:32], v);
            chk(tag_of(i), v, e[31:0]);
            if (e[33:32] == 2'd3)
                chk({tag_of(i), " irq pin"}, {31'd0, irq}, {31'd0, e[0]});
        end

        // R11 idle neighbour untouched, then exercise it
        rd_b(2'd0, v); chk("R11 neighbour count", v, 32'd0);
        chk("R11 neighbour irq", {31'd0, b_irq}, 32'd0);
        wr_b(2'd1, 8'd3);
        wr_b(2'd0, 8'd250);
        wr_b(2'd2, 8'd1);
        repeat (5) @(negedge clk);
        rd_b(2'd0, v); chk("R4 narrow top", v, 32'd255);
        @(negedge clk);
        rd_b(2'd0, v); chk("R4 narrow overflow", v, 32'd0);
        rd_a(2'd0, v); chk("R11 first instance count", v, 32'd1);
        chk("R11 first instance irq", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule